// File: doc/BRIEF.md
# Single-Precision Divide Special-Operand Resolver

This block is the combinational first stage of a single-precision floating-point divider. Both operands arrive as raw 32-bit words. The block sorts each operand into one of four groups: NaN (signalling or quiet), infinity, zero, or finite. Subnormal values count as finite. The block then decides whether the quotient can be produced at once, without running the mantissa division.

When the quotient can be produced at once, the block raises a bypass-valid output and drives the finished 32-bit result together with the invalid and divide-by-zero flags. When both operands are finite and non-zero, it instead raises a core-request output, and the sign of the quotient is handed on to the iterative divider.

The checks run in a fixed priority, in this order:

1. NaN operands.
2. The two indeterminate forms, 0/0 and inf/inf.
3. An infinite or zero dividend.
4. A zero divisor.
5. An infinite divisor.

Because an infinite or zero dividend is handled before a zero divisor, divide-by-zero can only be raised when the dividend is finite. For example, inf/0 gives a signed infinity and raises no flag.

Top module: `fdiv_special_resolve`

## Requirements
- R1: An operand is zero only when its exponent field (bits 30:23) and its fraction field (bits 22:0) are both all zero. An operand with a zero exponent and a non-zero fraction (a subnormal) is treated as finite.
- R2: If either operand is a NaN (exponent all ones, fraction non-zero), the result is that NaN with fraction bit 22 forced to 1. The dividend's NaN is chosen when both operands are NaN. Bypass-valid is 1 in this case.
- R3: The invalid flag is raised when either operand is a signalling NaN (NaN with fraction bit 22 clear). A pair in which every NaN is quiet raises no flag.
- R4: For non-NaN operands, 0/0 and inf/inf (any signs) give 0x7FC00000 with invalid set and divide-by-zero clear.
- R5: Otherwise, an infinite or zero dividend gives the dividend's bits 30:0 with the sign set to the XOR of the operand signs, and no flags. This includes inf/0.
- R6: Otherwise, a zero divisor gives an infinity (exponent all ones, fraction zero) with the XOR sign. The divide-by-zero flag is set and invalid is clear.
- R7: Otherwise, an infinite divisor gives a zero with the XOR sign and no flags.
- R8: Two finite non-zero operands give core-request 1, bypass-valid 0, and both flags 0.
- R9: Exactly one of bypass-valid and core-request is 1 at all times. Divide-by-zero is raised only for a finite non-zero dividend over a zero divisor.
- R10: The result-sign output always equals the XOR of the two operand sign bits (bit 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dvd | input | 32 | Dividend, single-precision bit pattern |
| dvs | input | 32 | Divisor, single-precision bit pattern |
| byp_valid | output | 1 | Result produced directly; core divide not required |
| byp_result | output | 32 | Directly produced quotient (zero word with sign when not bypassing) |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_dz | output | 1 | Divide-by-zero exception |
| need_core | output | 1 | Both operands finite non-zero; mantissa divide required |
| res_sign | output | 1 | Sign of the quotient |

## Verification
The block has no registers, so every output is due in the same cycle that the operands are applied. The bench drives a new operand pair just after a falling clock edge and then waits a quarter period before sampling all outputs. By then the combinational paths have settled, and no sample falls on the active edge. Each sample is compared with a bench-side model built from the priority list. The stimulus covers every pair of operand kinds under all four sign combinations, plus seeded random pairs.

// File: rtl/fdiv_special_resolve.sv
module fdiv_special_resolve #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] dvd,
  input  logic [EXP_W+FRAC_W:0] dvs,
  output logic                  byp_valid,
  output logic [EXP_W+FRAC_W:0] byp_result,
  output logic                  flag_invalid,
  output logic                  flag_dz,
  output logic                  need_core,
  output logic                  res_sign
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [FRAC_W-1:0] QBIT    = FRAC_W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0]      DFLT_NAN = {1'b0, EXP_MAX, QBIT};

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, a_snan, b_snan;

  assign ea = dvd[W-2:FRAC_W];
  assign eb = dvs[W-2:FRAC_W];
  assign fa = dvd[FRAC_W-1:0];
  assign fb = dvs[FRAC_W-1:0];

  assign a_zero = (ea == '0) && (fa == '0);
  assign b_zero = (eb == '0) && (fb == '0);
  assign a_inf  = (ea == EXP_MAX) && (fa == '0);
  assign b_inf  = (eb == EXP_MAX) && (fb == '0);
  assign a_nan  = (ea == EXP_MAX) && (fa != '0);
  assign b_nan  = (eb == EXP_MAX) && (fb != '0);
  assign a_snan = a_nan && !fa[FRAC_W-1];
  assign b_snan = b_nan && !fb[FRAC_W-1];

  assign res_sign = dvd[W-1] ^ dvs[W-1];

  always_comb begin
    byp_valid    = 1'b1;
    need_core    = 1'b0;
    flag_invalid = 1'b0;
    flag_dz      = 1'b0;
    byp_result   = {res_sign, {(W-1){1'b0}}};
    if (a_nan || b_nan) begin
      byp_result   = (a_nan ? dvd : dvs) | W'(QBIT);
      flag_invalid = a_snan || b_snan;
    end else if ((a_zero && b_zero) || (a_inf && b_inf)) begin
      byp_result   = DFLT_NAN;
      flag_invalid = 1'b1;
    end else if (a_inf || a_zero) begin
      byp_result   = {res_sign, dvd[W-2:0]};
    end else if (b_zero) begin
      byp_result   = {res_sign, EXP_MAX, {FRAC_W{1'b0}}};
      flag_dz      = 1'b1;
    end else if (b_inf) begin
      byp_result   = {res_sign, {(W-1){1'b0}}};
    end else begin
      byp_valid    = 1'b0;
      need_core    = 1'b1;
    end
  end
endmodule

// File: rtl/fdiv_special_resolve_chk.sv
module fdiv_special_resolve_chk (
  input logic [31:0] dvd,
  input logic [31:0] dvs,
  input logic        byp_valid,
  input logic [31:0] byp_result,
  input logic        flag_invalid,
  input logic        flag_dz,
  input logic        need_core,
  input logic        res_sign
);
  logic a_fin_nz, b_zero, any_nan;
  assign a_fin_nz = (dvd[30:23] != 8'hFF) && (dvd[30:0] != 31'd0);
  assign b_zero   = (dvs[30:0] == 31'd0);
  assign any_nan  = (dvd[30:23] == 8'hFF && dvd[22:0] != 0) ||
                    (dvs[30:23] == 8'hFF && dvs[22:0] != 0);

  always_comb begin
    // R9
    one_path_chk: assert (byp_valid ^ need_core);
    // R9
    dz_finite_only_chk: assert (!flag_dz || (a_fin_nz && b_zero && !any_nan));
    // R10
    sign_xor_chk: assert (res_sign == (dvd[31] ^ dvs[31]));
    // R8
    core_no_flag_chk: assert (!need_core || (!flag_invalid && !flag_dz));
    // R4
    invalid_gives_nan_chk: assert (!flag_invalid ||
                                   (byp_result[30:23] == 8'hFF && byp_result[22]));
    // R6
    dz_not_invalid_chk: assert (!(flag_dz && flag_invalid));
  end
endmodule

bind fdiv_special_resolve fdiv_special_resolve_chk u_chk (
  .dvd(dvd), .dvs(dvs), .byp_valid(byp_valid), .byp_result(byp_result),
  .flag_invalid(flag_invalid), .flag_dz(flag_dz),
  .need_core(need_core), .res_sign(res_sign)
);

// File: tb/sim_fdiv_special_resolve.sv
module sim_fdiv_special_resolve;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] dvd, dvs, byp_result;
  logic byp_valid, flag_invalid, flag_dz, need_core, res_sign;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fdiv_special_resolve u0 (
    .dvd(dvd), .dvs(dvs), .byp_valid(byp_valid), .byp_result(byp_result),
    .flag_invalid(flag_invalid), .flag_dz(flag_dz),
    .need_core(need_core), .res_sign(res_sign)
  );

  // kind: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 qnan, 5 snan
  function automatic logic [31:0] make_op(int kind, bit s, logic [31:0] r);
    case (kind)
      0: return {s, 31'd0};
      1: return {s, 8'h00, (r[22:0] == 0) ? 23'd1 : r[22:0]};
      2: return {s, (r[30:23] == 8'hFF || r[30:23] == 0) ? 8'h80 : r[30:23], r[22:0]};
      3: return {s, 8'hFF, 23'd0};
      4: return {s, 8'hFF, 1'b1, r[21:0]};
      default: return {s, 8'hFF, 1'b0, (r[21:0] == 0) ? 22'd5 : r[21:0]};
    endcase
  endfunction

  // expected {byp_valid, need_core, invalid, dz, sign, result}
  function automatic logic [36:0] model(logic [31:0] a, logic [31:0] b, output string tag);
    bit sg = a[31] ^ b[31];
    bit an = a[30:23] == 8'hFF && a[22:0] != 0;
    bit bn = b[30:23] == 8'hFF && b[22:0] != 0;
    bit ai = a[30:0] == {8'hFF, 23'd0};
    bit bi = b[30:0] == {8'hFF, 23'd0};
    bit az = a[30:0] == 0;
    bit bz = b[30:0] == 0;
    if (an || bn) begin
      tag = "R2/R3";
      return {1'b1, 1'b0, (an && !a[22]) || (bn && !b[22]), 1'b0, sg,
              (an ? a : b) | 32'h0040_0000};
    end
    if ((az && bz) || (ai && bi)) begin
      tag = "R4"; return {4'b1010, sg, 32'h7FC0_0000};
    end
    if (ai || az) begin tag = "R5"; return {4'b1000, sg, sg, a[30:0]}; end
    if (bz) begin tag = "R6"; return {4'b1001, sg, sg, 8'hFF, 23'd0}; end
    if (bi) begin tag = "R7"; return {4'b1000, sg, sg, 31'd0}; end
    tag = "R8/R1"; return {4'b0100, sg, sg, 31'd0};
  endfunction

  task automatic apply(logic [31:0] a, logic [31:0] b);
    string tag;
    logic [36:0] exp_v, got;
    @(negedge clk);
    dvd = a; dvs = b;
    #1.25;
    exp_v = model(a, b, tag);
    got = {byp_valid, need_core, flag_invalid, flag_dz, res_sign, byp_result};
    n_chk++;
    // R10 sign and R9 path selection are part of every comparison
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s/R9/R10 dvd=%h dvs=%h got=%h exp=%h", tag, a, b, got, exp_v);
    end
  endtask

  initial begin
    dvd = 0; dvs = 0;
    void'($urandom(32'd20240607));
    // R4 initial state: 0/0
    apply(32'h0, 32'h0);
    // R5: -inf/0 gives -inf, no flags
    apply(32'hFF80_0000, 32'h0);
    // R6: 1/-0 gives -inf with dz
    apply(32'h3F80_0000, 32'h8000_0000);
    // R1: subnormal divisor is not zero
    apply(32'h3F80_0000, 32'h0000_0001);
    // R2: both NaN, dividend chosen
    apply(32'h7F80_0001, 32'hFFC0_1234);
    // R3: quiet NaN only, no flag
    apply(32'h7FC0_0001, 32'h3F80_0000);
    // R7: finite over inf
    apply(32'hC000_0000, 32'h7F80_0000);
    for (int ka = 0; ka < 6; ka++)
      for (int kb = 0; kb < 6; kb++)
        for (int s = 0; s < 4; s++)
          apply(make_op(ka, s[1], $urandom), make_op(kb, s[0], $urandom));
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra = $urandom, rb = $urandom;
      apply(make_op($urandom_range(0, 5), ra[31], $urandom),
            make_op($urandom_range(0, 5), rb[31], $urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule